// File: doc/BRIEF.md
# Shared Pin Function Selector with PLL Clock Divider

This block decides what a shared chip-select/general-purpose pin does. A 3-bit function code picks one of several sources: the pin can be left as an input, driven from one of three internal status flags (temperature in range, automatic mute engaged, PLL locked), driven with a fixed low or high level, or driven with a divided copy of the PLL clock. A single invert bit flips whatever level is driven. When the control interface runs in its 3-wire mode, the pin is needed as the chip-select input, so it is forced to input regardless of the function code.

The clock source uses an integer divider in the PLL clock domain with ratios of 1, 2, 3 and 4, picked by a 2-bit code. Ratio 1 passes the PLL clock straight through. Ratios 2 and 4 give an even duty cycle. Ratio 3 is high for one PLL cycle and low for two. A new ratio is loaded only when the current divided period ends, so switching never produces a shortened pulse.

The pad itself is outside this block. The block presents a pin level and an active-high output-enable. While the enable is low, the level is held at 0.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: With function code 000 (input) or 001 (reserved), `pin_oe` is 0 and `pin_o` is 0.
- R2: While `three_wire` is 1, `pin_oe` is 0 and `pin_o` is 0 for every function code, status value and invert setting.
- R3: Codes 010, 011 and 101 drive `temp_ok`, `amute_act` and `pll_locked` respectively onto `pin_o` with `pin_oe` = 1, combinationally from the inputs.
- R4: Code 110 drives a constant 0 and code 111 drives a constant 1, with `pin_oe` = 1.
- R5: For every driving code (010 to 111), `invert` = 1 complements `pin_o`. While `pin_oe` is 0, `invert` has no effect on `pin_o`.
- R6: Code 100 with divider code 00 puts the PLL clock itself on `pin_o`: high while `clk_pll` is high and low while it is low (when `invert` = 0). This is also the divider state after reset.
- R7: Code 100 with divider code 01 gives a period of 2 PLL cycles, high for 1. Divider code 11 gives a period of 4, high for 2. Each divided period begins with its high phase on a rising PLL edge.
- R8: Code 100 with divider code 10 gives a period of 3 PLL cycles, high for 1 and low for 2.
- R9: A new divider code takes effect only at the end of the running divided period. Every high or low phase has the length that either the old ratio or the new ratio gives it, and the new ratio then repeats steadily.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pll | input | 1 | PLL clock; clocks the divider |
| rst | input | 1 | Synchronous active-high reset of the divider |
| three_wire | input | 1 | 1 when the control interface is in 3-wire mode (pin forced to input) |
| fsel | input | 3 | Pin function code |
| invert | input | 1 | Output polarity invert |
| div_sel | input | 2 | Clock divider code: 00=/1, 01=/2, 10=/3, 11=/4 |
| temp_ok | input | 1 | Temperature-in-range flag |
| amute_act | input | 1 | Automatic mute engaged flag |
| pll_locked | input | 1 | PLL lock flag |
| pin_o | output | 1 | Level to drive on the pin |
| pin_oe | output | 1 | Pin output-enable, active high |

## Verification
The bench sweeps every function code against every status pattern, both invert settings and both interface modes. This catches a mode override that only blocks some codes, a reserved code that drives the pin, or an inversion that leaks onto an undriven pin. The divider check runs each ratio and confirms period and high time arithmetically: a /3 built as /2 or /4 shows up as a wrong period, and an even ratio with a skewed duty cycle shows up as a wrong high count. For ratio changes made mid-period, every high and low phase length is compared against the old and new ratios. A divider that reloads its ratio at once would cut a phase short and be reported.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;

    localparam int FSEL_W  = 3;
    localparam int RATIO_W = 2;
    localparam int CNT_W   = RATIO_W;

    typedef enum logic [FSEL_W-1:0] {
        FN_INPUT  = 3'd0,
        FN_RSVD   = 3'd1,
        FN_TEMP   = 3'd2,
        FN_AMUTE  = 3'd3,
        FN_PLLCLK = 3'd4,
        FN_LOCK   = 3'd5,
        FN_LOW    = 3'd6,
        FN_HIGH   = 3'd7
    } pin_fn_e;

    typedef struct packed {
        logic drive;
        logic level;
    } pin_drv_t;

    // Count value at which a period of the given ratio code ends (ratio-1).
    function automatic logic [CNT_W-1:0] period_last(input logic [RATIO_W-1:0] code);
        return CNT_W'(code);
    endfunction

    // Number of PLL cycles the divided clock stays high for a ratio code.
    function automatic logic [CNT_W:0] high_cycles(input logic [RATIO_W-1:0] code);
        return (CNT_W+1)'((code + 1) >> 1) + ((code == '0) ? (CNT_W+1)'(1) : '0);
    endfunction

endpackage

// File: rtl/gpio_clk_divider.sv
module gpio_clk_divider
    import gpio_fsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_code,
    output logic               clk_div,
    output logic               div_level,
    output logic               ratio_one
);

    logic [RATIO_W-1:0] act_code;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cnt_nxt;
    logic               div_q;
    logic               period_end;

    assign period_end = (cnt == period_last(act_code));
    assign cnt_nxt    = cnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_code <= '0;
            cnt      <= '0;
            div_q    <= 1'b0;
        end else if (period_end) begin
            act_code <= ratio_code;
            cnt      <= '0;
            div_q    <= 1'b1;
        end else begin
            cnt      <= cnt_nxt;
            div_q    <= ({1'b0, cnt_nxt} < high_cycles(act_code));
        end
    end

    assign ratio_one = (act_code == '0);
    assign div_level = div_q;
    assign clk_div   = ratio_one ? clk : div_q;

endmodule

// File: rtl/gpio_func_mux.sv
module gpio_func_mux
    import gpio_fsel_pkg::*;
(
    input  logic              three_wire,
    input  logic [FSEL_W-1:0] fsel,
    input  logic              invert,
    input  logic              temp_ok,
    input  logic              amute_act,
    input  logic              pll_locked,
    input  logic              clk_div,
    output pin_drv_t          drv
);

    pin_fn_e fn;
    logic    raw;
    logic    drives;

    assign fn = pin_fn_e'(fsel);

    always_comb begin
        raw    = 1'b0;
        drives = 1'b1;
        unique case (fn)
            FN_INPUT:  drives = 1'b0;
            FN_RSVD:   drives = 1'b0;
            FN_TEMP:   raw = temp_ok;
            FN_AMUTE:  raw = amute_act;
            FN_PLLCLK: raw = clk_div;
            FN_LOCK:   raw = pll_locked;
            FN_LOW:    raw = 1'b0;
            FN_HIGH:   raw = 1'b1;
            default:   drives = 1'b0;
        endcase
        if (three_wire) drives = 1'b0;
        drv.drive = drives;
        drv.level = drives & (raw ^ invert);
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_fsel_pkg::*;
(
    input  logic               clk_pll,
    input  logic               rst,
    input  logic               three_wire,
    input  logic [FSEL_W-1:0]  fsel,
    input  logic               invert,
    input  logic [RATIO_W-1:0] div_sel,
    input  logic               temp_ok,
    input  logic               amute_act,
    input  logic               pll_locked,
    output logic               pin_o,
    output logic               pin_oe
);

    logic     clk_div;
    logic     div_level;
    logic     div_one;
    pin_drv_t drv;

    gpio_clk_divider u_div (
        .clk        (clk_pll),
        .rst        (rst),
        .ratio_code (div_sel),
        .clk_div    (clk_div),
        .div_level  (div_level),
        .ratio_one  (div_one)
    );

    gpio_func_mux u_mux (
        .three_wire (three_wire),
        .fsel       (fsel),
        .invert     (invert),
        .temp_ok    (temp_ok),
        .amute_act  (amute_act),
        .pll_locked (pll_locked),
        .clk_div    (clk_div),
        .drv        (drv)
    );

    assign pin_o  = drv.level;
    assign pin_oe = drv.drive;

endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk (
    input logic       clk_pll,
    input logic       rst,
    input logic       three_wire,
    input logic [2:0] fsel,
    input logic       invert,
    input logic       temp_ok,
    input logic       pll_locked,
    input logic       pin_o,
    input logic       pin_oe,
    input logic       div_level,
    input logic       div_one
);

    logic [2:0] high_run;

    always_ff @(posedge clk_pll) begin
        if (rst || !div_level || div_one) high_run <= '0;
        else if (high_run != 3'd7)        high_run <= high_run + 3'd1;
    end

    // R1: input and reserved codes never drive the pin
    a_r1_no_drive: assert property (@(posedge clk_pll) disable iff (rst)
        (fsel <= 3'd1) |-> (!pin_oe && !pin_o));

    // R2: 3-wire mode forces the pin to input
    a_r2_three_wire_input: assert property (@(posedge clk_pll) disable iff (rst)
        three_wire |-> (!pin_oe && !pin_o));

    // R3: temperature flag and lock flag routing
    a_r3_temp_route: assert property (@(posedge clk_pll) disable iff (rst)
        (!three_wire && fsel == 3'd2) |-> (pin_oe && pin_o == (temp_ok ^ invert)));
    a_r3_lock_route: assert property (@(posedge clk_pll) disable iff (rst)
        (!three_wire && fsel == 3'd5) |-> (pin_oe && pin_o == (pll_locked ^ invert)));

    // R4: constant levels
    a_r4_const_levels: assert property (@(posedge clk_pll) disable iff (rst)
        (!three_wire && fsel[2:1] == 2'b11) |-> (pin_oe && pin_o == (fsel[0] ^ invert)));

    // R7: no divided high phase is longer than two PLL cycles
    a_r7_high_bounded: assert property (@(posedge clk_pll) disable iff (rst)
        $fell(div_level) |-> (high_run <= 3'd2));

endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk u_chk (
    .clk_pll    (clk_pll),
    .rst        (rst),
    .three_wire (three_wire),
    .fsel       (fsel),
    .invert     (invert),
    .temp_ok    (temp_ok),
    .pll_locked (pll_locked),
    .pin_o      (pin_o),
    .pin_oe     (pin_oe),
    .div_level  (div_level),
    .div_one    (div_one)
);

// File: tb/gpio_pin_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       three_wire;
    logic [2:0] fsel;
    logic       invert;
    logic [1:0] div_sel;
    logic       temp_ok, amute_act, pll_locked;
    logic       pin_o, pin_oe;

    int  vectors = 0;
    int  miscompares = 0;
    bit  finished = 0;
    logic samp [0:47];

    always #2.5 clk = ~clk;

    gpio_pin_ctrl u_gpio_pin_ctrl (
        .clk_pll(clk), .rst(rst), .three_wire(three_wire), .fsel(fsel),
        .invert(invert), .div_sel(div_sel), .temp_ok(temp_ok),
        .amute_act(amute_act), .pll_locked(pll_locked),
        .pin_o(pin_o), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d (fsel=%0d tw=%0d inv=%0d div=%0d)",
                     req, act, exp, fsel, three_wire, invert, div_sel);
        end
    endtask

    function automatic int hi_of(input int code);
        return (code == 3) ? 2 : 1;
    endfunction

    task automatic grab(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            samp[i] = pin_o ^ invert;
        end
    endtask

    task automatic check_ratio(input int code);
        int n;
        int highs;
        n = code + 1;
        @(negedge clk); div_sel = code[1:0];
        repeat (10) @(posedge clk);
        grab(24);
        for (int i = 0; i < 12; i++) begin
            if (code == 0) chk("R6 ratio1 high phase", samp[i], 1);
            else if (code == 2) chk("R8 period 3", samp[i], samp[i+n]);
            else chk("R7 period", samp[i], samp[i+n]);
        end
        highs = 0;
        for (int i = 0; i < n; i++) highs += samp[i];
        if (code == 2) chk("R8 high cycles per period", highs, 1);
        else chk("R7/R6 high cycles per period", highs, hi_of(code));
        if (code == 0) begin
            @(negedge clk); #1;
            chk("R6 ratio1 low phase", pin_o, invert);
        end
    endtask

    task automatic check_switch(input int oldc, input int newc, input int at);
        int run;
        int lo_ok0, lo_ok1, hi_ok0, hi_ok1;
        bit first;
        @(negedge clk); div_sel = oldc[1:0];
        repeat (12) @(posedge clk);
        for (int i = 0; i < 48; i++) begin
            @(posedge clk); #1;
            samp[i] = pin_o ^ invert;
            if (i == at) div_sel = newc[1:0];
        end
        hi_ok0 = hi_of(oldc); hi_ok1 = hi_of(newc);
        lo_ok0 = oldc + 1 - hi_ok0; lo_ok1 = newc + 1 - hi_ok1;
        run = 1; first = 1;
        for (int i = 1; i < 48; i++) begin
            if (samp[i] == samp[i-1]) run++;
            else begin
                if (!first) begin
                    if (samp[i-1]) chk("R9 high phase length", run,
                                       (run == hi_ok0 || run == hi_ok1) ? run : hi_ok1);
                    else chk("R9 low phase length", run,
                             (run == lo_ok0 || run == lo_ok1) ? run : lo_ok1);
                end
                first = 0;
                run = 1;
            end
        end
        for (int i = 30; i < 40; i++) chk("R9 new ratio steady", samp[i], samp[i+newc+1]);
    endtask

    function automatic int exp_level(input int tw, input int fs, input int inv,
                                     input int st, input int clkv);
        int raw;
        if (tw != 0 || fs <= 1) return 0;
        case (fs)
            2: raw = st & 1;
            3: raw = (st >> 1) & 1;
            4: raw = clkv;
            5: raw = (st >> 2) & 1;
            6: raw = 0;
            default: raw = 1;
        endcase
        return raw ^ inv;
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; three_wire = 0; fsel = 0; invert = 0; div_sel = 0;
        temp_ok = 0; amute_act = 0; pll_locked = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset oe", pin_oe, 0);
        chk("R1 reset level", pin_o, 0);
        @(negedge clk); rst = 0;

        // Combinational sweep, sampled while clk is low (ratio 1 active: clock level 0)
        for (int tw = 0; tw < 2; tw++)
            for (int fs = 0; fs < 8; fs++)
                for (int inv = 0; inv < 2; inv++)
                    for (int st = 0; st < 8; st++) begin
                        @(negedge clk);
                        three_wire = tw[0]; fsel = fs[2:0]; invert = inv[0];
                        temp_ok = st[0]; amute_act = st[1]; pll_locked = st[2];
                        #1;
                        if (tw != 0) begin
                            chk("R2 oe forced off", pin_oe, 0);
                            chk("R2 level held low", pin_o, 0);
                        end else if (fs <= 1) begin
                            chk("R1 oe off", pin_oe, 0);
                            chk("R1/R5 level low, invert ignored", pin_o, 0);
                        end else begin
                            chk("R3/R4 oe on", pin_oe, 1);
                            if (fs == 6 || fs == 7)
                                chk("R4/R5 constant", pin_o, exp_level(tw, fs, inv, st, 0));
                            else if (fs == 4)
                                chk("R6/R5 clock low phase", pin_o, exp_level(tw, fs, inv, st, 0));
                            else
                                chk("R3/R5 status route", pin_o, exp_level(tw, fs, inv, st, 0));
                        end
                    end

        // Divider ratios, both polarities
        @(negedge clk); three_wire = 0; fsel = 3'd4;
        for (int inv = 0; inv < 2; inv++) begin
            @(negedge clk); invert = inv[0];
            for (int c = 0; c < 4; c++) check_ratio(c);
        end

        // Ratio changes in mid-period
        @(negedge clk); invert = 0;
        check_switch(3, 1, 13);
        check_switch(3, 2, 14);
        check_switch(2, 3, 13);
        check_switch(1, 2, 12);
        check_switch(2, 1, 15);
        check_switch(0, 2, 10);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule